// File: doc/BRIEF.md
# Cascaded Active-Low 4-to-16 Binary Decoder

This block turns a 4-bit code into a 16-wire active-low one-hot word. It is built from two identical 3-to-8 decoder slices. Each slice has three enable pins of mixed polarity: one is active high and two are active low. Each slice drives eight active-low outputs.

The most significant code bit chooses which slice may decode, so at most one slice drives a low output for any code. The three low-order code bits go to both slices as the select. A global active-low enable at the top forces all sixteen outputs high when it is deasserted. The design is purely combinational.

Top module: `dec4to16_casc`

## Requirements
- R1: A slice decodes only when its active-high enable `g1` is 1 and both of its active-low enables `g2aN` and `g2bN` are 0. In that state exactly one of its eight outputs is 0.
- R2: A slice with `g1`=0, or with `g2aN`=1, or with `g2bN`=1, holds all eight outputs at 1.
- R3: Slice select bits are weighted c=4, b=2 and a=1. An enabled slice drives output `yN[4c+2b+a]` low.
- R4: With `enN`=0 and `codeIn` in 0..7, `decN[codeIn]` is 0 and `decN[15:8]` are all 1.
- R5: With `enN`=0 and `codeIn` in 8..15, `decN[codeIn]` is 0 and `decN[7:0]` are all 1.
- R6: With `enN`=1, all sixteen `decN` bits are 1 for every code.
- R7: At the top, no more than one `decN` bit is 0 at any time. Exactly one bit is 0 while `enN`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| codeIn | input | 4 | Binary code to decode; bit 3 chooses the slice |
| enN | input | 1 | Global enable, active low |
| decN | output | 16 | One-hot decoded outputs, active low |

## Verification
The assertions evaluate after the combinational outputs have settled. They assume `codeIn` and `enN` always carry known 0/1 values. The bench drives both inputs from a single process at a clock edge and leaves them steady until the monitor samples on the opposite edge, so the outputs never show X or an intermediate value. The bench also drives every one of the 16 codes under both enable levels, and every combination of a standalone slice's three enables and three select bits.

// File: rtl/dec_pkg.sv
package dec_pkg;
  // Enable strobes for one 3-to-8 slice, mixed polarity
  typedef struct packed {
    logic g1;    // active high
    logic g2aN;  // active low
    logic g2bN;  // active low
  } sliceEn_t;
endpackage

// File: rtl/dec_slice.sv
module dec_slice #(
  parameter int SEL_W = 3,
  localparam int OUT_N = 1 << SEL_W
) (
  input  logic             g1,
  input  logic             g2aN,
  input  logic             g2bN,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_N-1:0] yN
);
  logic sliceOn;

  always_comb sliceOn = g1 & ~g2aN & ~g2bN;

  for (genvar i = 0; i < OUT_N; i++) begin : g_out
    always_comb yN[i] = ~(sliceOn & (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int SEL_W  = 3,
  localparam int HI_W    = CODE_W - SEL_W,
  localparam int SLICE_N = 1 << HI_W
) (
  input  logic [CODE_W-1:0] codeIn,
  input  logic              enN,
  output sliceEn_t          sliceEn [SLICE_N]
);
  logic [HI_W-1:0] hiBits;

  always_comb hiBits = codeIn[CODE_W-1:SEL_W];

  if (SLICE_N == 2) begin : g_pair
    // Low slice: top bit on an active-low pin, global enable on the other
    always_comb sliceEn[0] = '{g1: 1'b1, g2aN: hiBits[0], g2bN: enN};
    // High slice: top bit on the active-high pin
    always_comb sliceEn[1] = '{g1: hiBits[0], g2aN: enN, g2bN: 1'b0};
  end else begin : g_wide
    for (genvar k = 0; k < SLICE_N; k++) begin : g_sl
      always_comb sliceEn[k] = '{g1: (hiBits == HI_W'(k)), g2aN: enN, g2bN: 1'b0};
    end
  end
endmodule

// File: rtl/dec_datapath.sv
module dec_datapath
  import dec_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int SEL_W  = 3,
  localparam int SLICE_N = 1 << (CODE_W - SEL_W),
  localparam int SL_OUT  = 1 << SEL_W,
  localparam int OUT_N   = 1 << CODE_W
) (
  input  logic [SEL_W-1:0] selBits,
  input  sliceEn_t         sliceEn [SLICE_N],
  output logic [OUT_N-1:0] decN
);
  for (genvar k = 0; k < SLICE_N; k++) begin : g_slice
    dec_slice #(.SEL_W(SEL_W)) u_slice (
      .g1   (sliceEn[k].g1),
      .g2aN (sliceEn[k].g2aN),
      .g2bN (sliceEn[k].g2bN),
      .sel  (selBits),
      .yN   (decN[k*SL_OUT +: SL_OUT])
    );
  end
endmodule

// File: rtl/dec4to16_casc.sv
module dec4to16_casc
  import dec_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int SEL_W  = 3,
  localparam int SLICE_N = 1 << (CODE_W - SEL_W),
  localparam int OUT_N   = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] codeIn,
  input  logic              enN,
  output logic [OUT_N-1:0]  decN
);
  sliceEn_t sliceEn [SLICE_N];

  dec_ctrl #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_ctrl (
    .codeIn  (codeIn),
    .enN     (enN),
    .sliceEn (sliceEn)
  );

  dec_datapath #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_dp (
    .selBits (codeIn[SEL_W-1:0]),
    .sliceEn (sliceEn),
    .decN    (decN)
  );
endmodule

// File: rtl/dec4to16_casc_chk.sv
module dec4to16_casc_chk #(
  parameter int CODE_W = 4,
  localparam int OUT_N = 1 << CODE_W,
  localparam int HALF  = OUT_N / 2
) (
  input logic [CODE_W-1:0] codeIn,
  input logic              enN,
  input logic [OUT_N-1:0]  decN
);
  always_comb begin
    if (enN) begin
      AST_OFF_ALL_HIGH: assert (&decN); // R6
    end
    AST_AT_MOST_ONE_LOW: assert ($countones(~decN) <= 1); // R7
    if (!enN) begin
      AST_EXACTLY_ONE_LOW: assert ($countones(~decN) == 1); // R7
      AST_CODE_LINE_LOW: assert (decN[codeIn] == 1'b0); // R4
      if (!codeIn[CODE_W-1]) begin
        AST_UPPER_HALF_QUIET: assert (&decN[OUT_N-1:HALF]); // R4
      end else begin
        AST_LOWER_HALF_QUIET: assert (&decN[HALF-1:0]); // R5
      end
    end
  end
endmodule

bind dec4to16_casc dec4to16_casc_chk #(.CODE_W(CODE_W)) u_chk (
  .codeIn (codeIn),
  .enN    (enN),
  .decN   (decN)
);

// File: tb/dec4to16_casc_tb.sv
module dec4to16_casc_tb;
  typedef struct {
    logic [15:0] expTop;
    logic [3:0]  code;
    logic        en;
    logic [7:0]  expSl;
    logic [2:0]  slEn;
    logic [2:0]  slSel;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  codeIn = 4'd0;
  logic        enN = 1'b1;
  logic [15:0] decN;
  logic g1 = 1'b0, g2aN = 1'b1, g2bN = 1'b1;
  logic [2:0] sel = 3'd0;
  logic [7:0] yN;
  item_t q[$];
  int total = 0;
  int bad = 0;
  bit driveDone = 1'b0;

  always #5 clk = ~clk;

  dec4to16_casc u_dut (.codeIn(codeIn), .enN(enN), .decN(decN));
  dec_slice #(.SEL_W(3)) u_slice (.g1(g1), .g2aN(g2aN), .g2bN(g2bN), .sel(sel), .yN(yN));

  task automatic drive(input logic [3:0] c, input logic e, input logic [2:0] se, input logic [2:0] ss);
    item_t it;
    @(posedge clk);
    codeIn = c; enN = e;
    {g1, g2aN, g2bN} = se; sel = ss;
    it.code = c; it.en = e; it.slEn = se; it.slSel = ss;
    it.expTop = e ? 16'hFFFF : ~(16'h0001 << c);
    it.expSl = (se == 3'b100) ? ~(8'h01 << ss) : 8'hFF;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (decN !== it.expTop) begin
          bad++;
          if (it.en) $display("FAIL R6 code=%0d act=%h exp=%h", it.code, decN, it.expTop);
          else if (it.code < 8) $display("FAIL R4/R7 code=%0d act=%h exp=%h", it.code, decN, it.expTop);
          else $display("FAIL R5/R7 code=%0d act=%h exp=%h", it.code, decN, it.expTop);
        end
        total++;
        if (yN !== it.expSl) begin
          bad++;
          if (it.slEn == 3'b100) $display("FAIL R1/R3 en=%b sel=%0d act=%h exp=%h", it.slEn, it.slSel, yN, it.expSl);
          else $display("FAIL R2 en=%b sel=%0d act=%h exp=%h", it.slEn, it.slSel, yN, it.expSl);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: disabled, all outputs high (R6, R2)
    drive(4'd0, 1'b1, 3'b011, 3'd0);
    // R4, R5, R6, R7: every code under both enable levels
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 16; c++)
        drive(4'(c), 1'(e), 3'b100, 3'(c));
    // R1, R2, R3: every slice enable / select combination
    for (int se = 0; se < 8; se++)
      for (int s = 0; s < 8; s++)
        drive(4'(s), 1'b0, 3'(se), 3'(s));
    @(posedge clk);
    @(posedge clk);
    driveDone = 1'b1;
    wait (q.size() == 0);
    @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule